// File: doc/BRIEF.md
# CPU Clock Prescaler and Power-Down Controller

This block sits between the oscillator and the clocked logic of a small 8-bit microcontroller. It runs on the oscillator clock and produces clock-enable strobes: one for the CPU core and the watchdog, and separate ones for the USB logic and for the general peripherals. A 3-bit divider code slows only the CPU/watchdog strobe, so firmware can run at a low rate while serial ports, timers and USB keep their full rate. The watchdog strobe is always the same as the CPU strobe.

An auto-restore flag lets any interrupt request force the divider code back to full speed. A power-down bit stops every strobe and drops the oscillator run enable. Once power-down is entered, only a reset can end it. That reset comes from the external reset pin, the low-voltage detector or a debug command. A watchdog reset cannot end it, because the watchdog clock is stopped. A reset clears only this block's own control state: the divider code, the auto-restore flag and the power-down bit.

Top module: `mcu_clkpm`

## Requirements
- R1: After `rst`, `pd_active`=0, `div_sel`=0, `div_act`=0, `auto_en`=0, and `cpu_ce`, `periph_ce`, `usb_ce` and `osc_run` are all 1.
- R2: The divider code sets the CPU strobe period in oscillator cycles: 000=1, 001=2, 010=4, 011=8, 100=16, 101=32, 110=1024, 111=2048. Code 000 gives a strobe on every cycle.
- R3: `wdt_ce` equals `cpu_ce` on every cycle.
- R4: Outside power-down, `periph_ce` and `usb_ce` are 1 on every cycle, whatever the divider code.
- R5: When `auto_en` is 1 and power-down is not active, `irq` sets `div_sel` to 000 on the next cycle. This overrides a same-cycle write. When `auto_en` is 0, `irq` leaves `div_sel` unchanged.
- R6: One cycle after `pd_set` is sampled, `pd_active` is 1 and `cpu_ce`, `wdt_ce`, `periph_ce`, `usb_ce` and `osc_run` are all 0. They stay 0 for as long as power-down lasts.
- R7: During power-down, `irq`, `cfg_we` and `wdt_rst_req` have no effect. `pd_active`, `div_sel` and `auto_en` keep their values.
- R8: A pulse on `ext_rst_req`, `lvd_rst_req` or `dbg_rst_req` ends power-down. On the next cycle `pd_active`=0, `div_sel`=0 and `auto_en`=0.
- R9: Outside power-down, `wdt_rst_req` clears `div_sel`, `auto_en` and the divider phase, the same way the other reset sources do.
- R10: A new divider code takes effect only when the current CPU strobe period ends. `div_act` shows the code in force, and it changes only on a cycle where `cpu_ce` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_req | input | 1 | Reset request from the external reset pin |
| lvd_rst_req | input | 1 | Reset request from the low-voltage detector |
| dbg_rst_req | input | 1 | Reset request from the debug unit |
| wdt_rst_req | input | 1 | Reset request from the watchdog |
| cfg_we | input | 1 | Write strobe for the divider code and the auto-restore flag |
| cfg_div | input | 3 | Divider code to write |
| cfg_auto | input | 1 | Auto-restore flag to write |
| pd_set | input | 1 | Request to enter power-down |
| irq | input | 1 | Combined interrupt request |
| cpu_ce | output | 1 | CPU clock enable (divided) |
| wdt_ce | output | 1 | Watchdog clock enable (same as the CPU enable) |
| periph_ce | output | 1 | Peripheral clock enable (undivided) |
| usb_ce | output | 1 | USB clock enable (undivided) |
| osc_run | output | 1 | Oscillator run enable |
| pd_active | output | 1 | Power-down state |
| div_sel | output | 3 | Divider code register |
| div_act | output | 3 | Divider code in force for the current period |
| auto_en | output | 1 | Auto-restore flag |

## Verification
The hardest situation to reach is a code change partway through a long period. The test is also meaningful only when the strobe gaps are measured exactly. The stimulus loads code 111, waits until `div_act` reports it, and then writes code 001 ten cycles into the 2048-cycle period. The bench then times the gap to the next strobe. It also checks that the faster rate starts only after that strobe. Power-down is entered three times, each time holding a non-zero code and auto-restore. Interrupts, writes and a watchdog pulse are applied while the block is powered down, and each of the three wake sources ends one of the three power-downs.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    localparam int CODE_W = 3;
    localparam int CNT_W  = 11;

    typedef logic [CODE_W-1:0] div_code_t;
    typedef logic [CNT_W-1:0]  div_cnt_t;

    typedef struct packed {
        div_code_t div;
        logic      auto_en;
        logic      pd;
    } clk_ctl_t;

    // log2 of the strobe period for a code; the two slowest codes skip ahead
    function automatic int unsigned code_shift(div_code_t c);
        return (c >= div_code_t'(6)) ? (int'(c) + 4) : int'(c);
    endfunction

    function automatic div_cnt_t period_last(div_code_t c);
        return div_cnt_t'((32'd1 << code_shift(c)) - 32'd1);
    endfunction

endpackage

// File: rtl/clkpm_regs.sv
module clkpm_regs
    import clkpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ext_rst_req,
    input  logic      lvd_rst_req,
    input  logic      dbg_rst_req,
    input  logic      wdt_rst_req,
    input  logic      cfg_we,
    input  div_code_t cfg_div,
    input  logic      cfg_auto,
    input  logic      pd_set,
    input  logic      irq,
    output clk_ctl_t  ctl_o,
    output logic      clr_o
);

    clk_ctl_t ctl_q;
    logic     wake_src;

    assign wake_src = ext_rst_req | lvd_rst_req | dbg_rst_req;
    // the watchdog cannot reach this block while its clock is stopped
    assign clr_o    = rst | wake_src | (wdt_rst_req & ~ctl_q.pd);
    assign ctl_o    = ctl_q;

    always_ff @(posedge clk) begin
        if (clr_o) begin
            ctl_q <= '0;
        end else if (!ctl_q.pd) begin
            if (pd_set) begin
                ctl_q.pd <= 1'b1;
            end
            if (cfg_we) begin
                ctl_q.div     <= cfg_div;
                ctl_q.auto_en <= cfg_auto;
            end
            if (irq && ctl_q.auto_en) begin
                ctl_q.div <= '0;
            end
        end
    end

    AST_PD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pd && !wake_src) |=> ctl_q.pd);  // R7
    AST_PD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pd && !wake_src) |=> ($stable(ctl_q.div) && $stable(ctl_q.auto_en)));  // R7
    AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wake_src |=> (!ctl_q.pd && ctl_q.div == '0 && !ctl_q.auto_en));  // R8
    AST_AUTO_RESTORE: assert property (@(posedge clk) disable iff (clr_o)
        (irq && ctl_q.auto_en && !ctl_q.pd) |=> (ctl_q.div == '0));  // R5

endmodule

// File: rtl/clkpm_divider.sv
module clkpm_divider
    import clkpm_pkg::*;
(
    input  logic      clk,
    input  logic      clr,
    input  logic      halt,
    input  div_code_t sel,
    output logic      ce_o,
    output div_code_t act_o
);

    div_cnt_t  cnt_q;
    div_code_t act_q;
    logic      wrap;

    assign wrap  = (cnt_q == '0);
    assign ce_o  = ~halt & wrap;
    assign act_o = act_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (!halt) begin
            if (wrap) begin
                cnt_q <= period_last(sel);
                act_q <= sel;
            end else begin
                cnt_q <= cnt_q - div_cnt_t'(1);
            end
        end
    end

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (clr)
        (ce_o && sel == '0) |=> (ce_o || halt));  // R2
    AST_NO_RUNT: assert property (@(posedge clk) disable iff (clr)
        !ce_o |=> $stable(act_q));  // R10
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (clr)
        halt |=> $stable(cnt_q));  // R6

endmodule

// File: rtl/clkpm_gate.sv
module clkpm_gate (
    input  logic cpu_tick,
    input  logic halt,
    output logic cpu_ce,
    output logic wdt_ce,
    output logic periph_ce,
    output logic usb_ce,
    output logic osc_run
);

    assign cpu_ce    = cpu_tick & ~halt;
    assign wdt_ce    = cpu_tick & ~halt;
    assign periph_ce = ~halt;
    assign usb_ce    = ~halt;
    assign osc_run   = ~halt;

endmodule

// File: rtl/mcu_clkpm.sv
module mcu_clkpm
    import clkpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_req,
    input  logic              lvd_rst_req,
    input  logic              dbg_rst_req,
    input  logic              wdt_rst_req,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_div,
    input  logic              cfg_auto,
    input  logic              pd_set,
    input  logic              irq,
    output logic              cpu_ce,
    output logic              wdt_ce,
    output logic              periph_ce,
    output logic              usb_ce,
    output logic              osc_run,
    output logic              pd_active,
    output logic [CODE_W-1:0] div_sel,
    output logic [CODE_W-1:0] div_act,
    output logic              auto_en
);

    clk_ctl_t  ctl;
    logic      clr;
    logic      tick;
    div_code_t act;

    clkpm_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .ext_rst_req (ext_rst_req),
        .lvd_rst_req (lvd_rst_req),
        .dbg_rst_req (dbg_rst_req),
        .wdt_rst_req (wdt_rst_req),
        .cfg_we      (cfg_we),
        .cfg_div     (cfg_div),
        .cfg_auto    (cfg_auto),
        .pd_set      (pd_set),
        .irq         (irq),
        .ctl_o       (ctl),
        .clr_o       (clr)
    );

    clkpm_divider u_div (
        .clk   (clk),
        .clr   (clr),
        .halt  (ctl.pd),
        .sel   (ctl.div),
        .ce_o  (tick),
        .act_o (act)
    );

    clkpm_gate u_gate (
        .cpu_tick  (tick),
        .halt      (ctl.pd),
        .cpu_ce    (cpu_ce),
        .wdt_ce    (wdt_ce),
        .periph_ce (periph_ce),
        .usb_ce    (usb_ce),
        .osc_run   (osc_run)
    );

    assign pd_active = ctl.pd;
    assign div_sel   = ctl.div;
    assign div_act   = act;
    assign auto_en   = ctl.auto_en;

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> (!cpu_ce && !wdt_ce && !periph_ce && !usb_ce && !osc_run));  // R6
    AST_WDT_TRACKS: assert property (@(posedge clk) disable iff (rst)
        wdt_ce == cpu_ce);  // R3
    AST_PERIPH_FULL: assert property (@(posedge clk) disable iff (rst)
        !pd_active |-> (periph_ce && usb_ce));  // R4
    AST_PD_ENTRY: assert property (@(posedge clk) disable iff (clr)
        (pd_set && !pd_active) |=> pd_active);  // R6

endmodule

// File: tb/mcu_clkpm_tb_top.sv
module mcu_clkpm_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       ext_rst_req = 1'b0, lvd_rst_req = 1'b0, dbg_rst_req = 1'b0, wdt_rst_req = 1'b0;
    logic       cfg_we = 1'b0, cfg_auto = 1'b0, pd_set = 1'b0, irq = 1'b0;
    logic [2:0] cfg_div = 3'd0;
    logic       cpu_ce, wdt_ce, periph_ce, usb_ce, osc_run, pd_active, auto_en;
    logic [2:0] div_sel, div_act;

    mcu_clkpm dut_i (
        .clk(clk), .rst(rst), .ext_rst_req(ext_rst_req), .lvd_rst_req(lvd_rst_req),
        .dbg_rst_req(dbg_rst_req), .wdt_rst_req(wdt_rst_req), .cfg_we(cfg_we),
        .cfg_div(cfg_div), .cfg_auto(cfg_auto), .pd_set(pd_set), .irq(irq),
        .cpu_ce(cpu_ce), .wdt_ce(wdt_ce), .periph_ce(periph_ce), .usb_ce(usb_ce),
        .osc_run(osc_run), .pd_active(pd_active), .div_sel(div_sel),
        .div_act(div_act), .auto_en(auto_en)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_req = 0, m_auto = 0, m_pd = 0, m_act = 0, m_len = 1, m_phase = 0;

    function automatic int period_of(int code);
        int p;
        p = 1;
        for (int i = 0; i < code; i++) p = p * 2;
        if (code >= 6) p = p * 16;
        return p;
    endfunction

    always @(posedge clk) begin
        int old_req;
        int old_auto;
        bit clr;
        cycles++;
        started = 1;
        old_req = m_req;
        old_auto = m_auto;
        clr = rst || ext_rst_req || lvd_rst_req || dbg_rst_req || (wdt_rst_req && m_pd == 0);
        if (clr) begin
            m_req = 0; m_auto = 0; m_pd = 0; m_act = 0; m_len = 1; m_phase = 0;
        end else if (m_pd == 0) begin
            if (m_phase == 0) begin
                m_len = period_of(old_req);
                m_act = old_req;
                m_phase = (m_len == 1) ? 0 : 1;
            end else begin
                m_phase = (m_phase + 1 == m_len) ? 0 : m_phase + 1;
            end
            if (pd_set) m_pd = 1;
            if (cfg_we) begin
                m_req = int'(cfg_div);
                m_auto = int'(cfg_auto);
            end
            if (irq && old_auto == 1) m_req = 0;
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            int e_ce;
            e_ce = (m_pd == 0 && m_phase == 0) ? 1 : 0;
            chk("R2 cpu_ce", int'(cpu_ce), e_ce);
            chk("R3 wdt_ce", int'(wdt_ce), e_ce);
            chk("R4 periph_ce", int'(periph_ce), 1 - m_pd);
            chk("R4 usb_ce", int'(usb_ce), 1 - m_pd);
            chk("R6 osc_run", int'(osc_run), 1 - m_pd);
            chk("R7 pd_active", int'(pd_active), m_pd);
            chk("R5 div_sel", int'(div_sel), m_req);
            chk("R10 div_act", int'(div_act), m_act);
            chk("R9 auto_en", int'(auto_en), m_auto);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulses();
        cfg_we = 0; pd_set = 0; irq = 0; wdt_rst_req = 0;
        ext_rst_req = 0; lvd_rst_req = 0; dbg_rst_req = 0; rst = 0;
    endtask

    task automatic write_cfg(int code, int au);
        cfg_div = 3'(code); cfg_auto = au[0]; cfg_we = 1;
        step(); clear_pulses();
    endtask

    task automatic wait_act(int code);
        int guard;
        guard = 0;
        while (int'(div_act) != code && guard < 5000) begin
            step(); guard++;
        end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int cnt;
        step(3);
        // R1 reset state
        chk("R1 pd_active", int'(pd_active), 0);
        chk("R1 div_sel", int'(div_sel), 0);
        chk("R1 cpu_ce", int'(cpu_ce), 1);
        chk("R1 osc_run", int'(osc_run), 1);
        rst = 0;
        step(2);

        // R2 strobe count over 4096 cycles for every code
        for (int k = 0; k < 8; k++) begin
            write_cfg(0, 0);
            step(2100);
            write_cfg(k, 0);
            wait_act(k);
            cnt = 0;
            for (int c = 0; c < 4096; c++) begin
                if (cpu_ce) cnt++;
                if (!periph_ce || !usb_ce) cnt = -99999; // R4 violation shows as a mismatch
                step();
            end
            chk("R2 strobe count", cnt, 4096 / period_of(k));
        end

        // R10 change lands only at period end
        write_cfg(0, 0);
        step(2100);
        write_cfg(7, 0);
        wait_act(7);
        step(10);
        write_cfg(1, 0);
        cnt = 11;
        while (!cpu_ce && cnt < 5000) begin
            chk("R10 act held", int'(div_act), 7);
            step(); cnt++;
        end
        chk("R10 period length", cnt, 2047);
        step();
        chk("R10 new code active", int'(div_act), 1);

        // R5 auto-restore on interrupt
        write_cfg(5, 1);
        wait_act(5);
        step(3);
        irq = 1; cfg_div = 3'd6; cfg_we = 1; cfg_auto = 1;
        step(); clear_pulses();
        chk("R5 irq forces 000", int'(div_sel), 0);
        cnt = 0;
        while (!cpu_ce && cnt < 100) begin step(); cnt++; end
        chk("R5 strobe within period", (cnt <= 32) ? 1 : 0, 1);
        write_cfg(4, 0);
        irq = 1; step(); clear_pulses();
        chk("R5 irq without auto", int'(div_sel), 4);

        // R6/R7/R8 power-down with each wake source
        for (int s = 0; s < 3; s++) begin
            write_cfg(3, 1);
            step(20);
            pd_set = 1; step(); clear_pulses();
            chk("R6 pd entered", int'(pd_active), 1);
            chk("R6 cpu_ce off", int'(cpu_ce), 0);
            chk("R6 periph off", int'(periph_ce), 0);
            chk("R6 usb off", int'(usb_ce), 0);
            chk("R6 osc off", int'(osc_run), 0);
            irq = 1; step(); clear_pulses();
            write_cfg(2, 0);
            wdt_rst_req = 1; step(); clear_pulses();
            step(5);
            chk("R7 pd kept", int'(pd_active), 1);
            chk("R7 div kept", int'(div_sel), 3);
            chk("R7 auto kept", int'(auto_en), 1);
            chk("R7 wdt_ce off", int'(wdt_ce), 0);
            if (s == 0) ext_rst_req = 1;
            else if (s == 1) lvd_rst_req = 1;
            else dbg_rst_req = 1;
            step(); clear_pulses();
            chk("R8 pd left", int'(pd_active), 0);
            chk("R8 div cleared", int'(div_sel), 0);
            chk("R8 cpu_ce back", int'(cpu_ce), 1);
        end

        // R9 watchdog reset while running
        write_cfg(6, 1);
        step(5);
        wdt_rst_req = 1; step(); clear_pulses();
        chk("R9 div cleared", int'(div_sel), 0);
        chk("R9 auto cleared", int'(auto_en), 0);
        chk("R9 full rate", int'(cpu_ce), 1);

        step(5);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule